// File: doc/BRIEF.md
# Dual Outstanding Read Tracker

This block keeps the bookkeeping for read requests that a processor's bus interface has sent out and that have not yet been answered. It holds at most two pending reads. For each one it stores the byte address, whether the read fetches instructions or data, whether it is a single transfer of 1 to 8 bytes or a 32-byte block, and a 3-bit byte-count code. When response data comes back, the block works out which pending read the data belongs to. It then presents that read's fill address and attributes to the cache write logic and pulses a completion output when the read is finished.

The responding agent may answer the younger read first. It announces this by raising a swap input exactly two cycles before the first data beat. This lets the tracker steer the fill address onto the younger entry before the data arrives. Without that warning, data always goes to the oldest pending read. A static mode input, fixed while reset is held, limits the tracker to one pending read instead of two.

Top module: `rd_track`

## Requirements
- R1: `req_ready` is high while fewer than two reads are pending when `dual_en`=1, and only while none is pending when `dual_en`=0. A request offered while `req_ready` is low is not recorded and never completes.
- R2: After reset no read is pending, `req_ready` is 1, and `cmpl` and `swap_err` are 0.
- R3: When `swap_in` was high two cycles before the first beat of a response and two reads are pending, the response belongs to the younger read.
- R4: When `swap_in` was low two cycles before the first beat, the response belongs to the oldest pending read. A beat that arrives with no read pending gives no completion.
- R5: `fill_instr` (1 = instruction fetch, 0 = data), `fill_len` (byte count minus one) and the stored address are taken from `req_instr`, `req_len` and `req_addr` only in the cycle a request is accepted. Changes on those inputs at other times do not affect them.
- R6: A block read (`req_block`=1) is answered by 4 beats of 8 bytes. On beat k (0..3), `fill_addr` equals the address with its low 5 bits replaced by k×8. `cmpl` pulses only on the fourth beat, and the entry is then freed.
- R7: A single transfer is answered by one beat. On that beat `fill_addr` equals the stored address, including its low 3 offset bits, and `cmpl` pulses.
- R8: `swap_err` goes high in the cycle after `swap_in` is sampled high while fewer than two reads are pending.
- R9: When one of two pending reads completes, the remaining read becomes the oldest. A following response without a swap warning goes to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_en | input | 1 | 1: two pending reads allowed; 0: one |
| req_valid | input | 1 | A read request is offered this cycle |
| req_addr | input | AW | Byte address of the request |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_block | input | 1 | 1 = 32-byte block, 0 = single transfer |
| req_len | input | 3 | Byte count minus one for single transfers |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| swap_in | input | 1 | Next response, two cycles on, is for the younger read |
| resp_valid | input | 1 | A response data beat is present |
| cmpl | output | 1 | Last beat of a read; its entry is freed |
| cmpl_slot | output | 1 | Entry the current beat belongs to |
| fill_addr | output | AW | Address for writing the current beat |
| fill_instr | output | 1 | Stored fetch type of the selected entry |
| fill_block | output | 1 | Stored block flag of the selected entry |
| fill_len | output | 3 | Stored byte-count code of the selected entry |
| swap_err | output | 1 | Swap warning seen with fewer than two pending |

## Verification
The bench builds the tracker with its defaults: a 32-bit address and 4 beats per block. The block address walk therefore covers every beat index, and the top address bits are exercised with an address near the top of the space. The table covers both response orders with distinct address offsets. Directed tests then run the one-read mode with a stalled request, a block read followed by a pending single read, the swap misuse error, and a change on the fetch-type input outside the accept cycle.

// File: rtl/rd_track.sv
module rd_track #(
  parameter int AW        = 32,
  parameter int BLK_BEATS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dual_en,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_instr,
  input  logic          req_block,
  input  logic [2:0]    req_len,
  output logic          req_ready,
  input  logic          swap_in,
  input  logic          resp_valid,
  output logic          cmpl,
  output logic          cmpl_slot,
  output logic [AW-1:0] fill_addr,
  output logic          fill_instr,
  output logic          fill_block,
  output logic [2:0]    fill_len,
  output logic          swap_err
);
  localparam int BW   = $clog2(BLK_BEATS);
  localparam int OFFW = BW + 3;

  logic [AW-1:0] e_addr [2];
  logic [2:0]    e_len  [2];
  logic [1:0]    e_instr, e_blk;
  logic [1:0]    vld, vld_n;
  logic          old, cur, sw1, sw2;
  logic [BW-1:0] beat;

  logic busy, both, tgt, hit, last, alloc, aslot;

  assign both   = (vld == 2'b11);
  assign busy   = (beat != '0);
  assign tgt    = busy ? cur : ((sw2 && both) ? ~old : old);
  assign hit    = resp_valid && vld[tgt];
  assign last   = !e_blk[tgt] || (beat == BW'(BLK_BEATS - 1));
  assign cmpl   = hit && last;
  assign cmpl_slot = tgt;

  assign req_ready = dual_en ? !both : (vld == 2'b00);
  assign alloc     = req_valid && req_ready;
  assign aslot     = vld[old] ? ~old : old;

  assign fill_addr  = e_blk[tgt] ? {e_addr[tgt][AW-1:OFFW], beat, 3'b000} : e_addr[tgt];
  assign fill_instr = e_instr[tgt];
  assign fill_block = e_blk[tgt];
  assign fill_len   = e_len[tgt];

  always_comb begin
    vld_n = vld;
    if (cmpl)  vld_n[tgt]   = 1'b0;
    if (alloc) vld_n[aslot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      old      <= 1'b0;
      cur      <= 1'b0;
      sw1      <= 1'b0;
      sw2      <= 1'b0;
      beat     <= '0;
      swap_err <= 1'b0;
    end else begin
      vld      <= vld_n;
      sw1      <= swap_in;
      sw2      <= sw1;
      swap_err <= swap_in && !both;
      if (cmpl && tgt == old) old <= ~old;
      if (hit) begin
        if (!busy) cur <= tgt;
        beat <= last ? '0 : beat + BW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      e_addr[aslot]  <= req_addr;
      e_len[aslot]   <= req_len;
      e_instr[aslot] <= req_instr;
      e_blk[aslot]   <= req_block;
    end
  end

  a_r1_single_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |-> $countones(vld) <= 1);
  a_r1_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> !req_ready);
  a_r3_swap_young: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !busy && both && $past(swap_in, 2)) |-> (cmpl_slot != old));
  a_r4_cmpl_live: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |-> vld[cmpl_slot]);
  a_r6_freed: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> !vld[$past(cmpl_slot)]);
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    swap_err |-> ($past(swap_in) && $countones($past(vld)) < 2));
endmodule

// File: tb/tb_rd_track.sv
module tb_rd_track;
  localparam int AW = 32;

  logic          clk = 0, rst_n = 0, dual_en = 1;
  logic          req_valid = 0, req_instr = 0, req_block = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0]    req_len = '0;
  logic          swap_in = 0, resp_valid = 0;
  logic          req_ready, cmpl, cmpl_slot, fill_instr, fill_block, swap_err;
  logic [AW-1:0] fill_addr;
  logic [2:0]    fill_len;
  int checks = 0, errors = 0;
  bit finished = 0;

  rd_track #(.AW(AW), .BLK_BEATS(4)) dut (.*);

  always #4 clk = ~clk;

  // A addr, B addr, swap, expected first addr, expected first instr, expected second addr
  localparam int NV = 4;
  localparam logic [31:0] VA [NV] = '{32'h0000_0100, 32'h0000_3005, 32'hFFFF_FFF8, 32'h0000_0055};
  localparam logic [31:0] VB [NV] = '{32'h0000_0208, 32'h0000_4003, 32'h0000_0001, 32'h0000_00AA};
  localparam logic        VS [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] E1 [NV] = '{32'h0000_0100, 32'h0000_4003, 32'h0000_0001, 32'h0000_0055};
  localparam logic        I1 [NV] = '{1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [31:0] E2 [NV] = '{32'h0000_0208, 32'h0000_3005, 32'hFFFF_FFF8, 32'h0000_00AA};

  task automatic chk(string r, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic issue(logic [AW-1:0] a, logic ins, logic blk, logic [2:0] len);
    req_valid = 1; req_addr = a; req_instr = ins; req_block = blk; req_len = len;
    tick;
    req_valid = 0; req_instr = 0; req_block = 0; req_len = 0;
  endtask

  task automatic do_reset(logic mode);
    rst_n = 0; dual_en = mode;
    repeat (3) tick;
    rst_n = 1;
    #2;
    chk("R2 ready", req_ready, 1);
    chk("R2 cmpl", cmpl, 0);
    chk("R2 swap_err", swap_err, 0);
    tick;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(1);

    for (int i = 0; i < NV; i++) begin
      issue(VA[i], 1'b1, 1'b0, 3'd3);
      issue(VB[i], 1'b0, 1'b0, 3'd5);
      #1 chk("R1 full", req_ready, 0);
      swap_in = VS[i];
      tick;
      swap_in = 0;
      chk("R8 no err with two pending", swap_err, 0);
      tick;
      resp_valid = 1;
      #2;
      chk(VS[i] ? "R3 first addr" : "R4 first addr", fill_addr, E1[i]);
      chk("R5 first instr", fill_instr, I1[i]);
      chk("R7 first cmpl", cmpl, 1);
      tick;
      #2;
      chk("R9 second addr", fill_addr, E2[i]);
      chk("R7 second cmpl", cmpl, 1);
      tick;
      resp_valid = 0;
      #1 chk("R1 ready after drain", req_ready, 1);
    end

    // one-read mode, stalled request is dropped
    do_reset(0);
    issue(32'h0000_7000, 1'b1, 1'b0, 3'd7);
    #1 chk("R1 single stall", req_ready, 0);
    req_valid = 1; req_addr = 32'h0000_9000;
    tick;
    req_valid = 0;
    resp_valid = 1;
    #2;
    chk("R5 len", fill_len, 7);
    chk("R5 instr", fill_instr, 1);
    chk("R7 addr", fill_addr, 32'h0000_7000);
    chk("R7 cmpl", cmpl, 1);
    tick;
    #2;
    chk("R1 stalled req not recorded", cmpl, 0);
    chk("R1 ready again", req_ready, 1);
    tick;
    resp_valid = 0;

    // block read with a single read queued behind it
    do_reset(1);
    issue(32'h1000_0047, 1'b0, 1'b1, 3'd0);
    issue(32'h0000_2222, 1'b1, 1'b0, 3'd1);
    tick;
    resp_valid = 1;
    for (int b = 0; b < 4; b++) begin
      #2;
      chk("R6 beat addr", fill_addr, 32'h1000_0040 + 32'(b * 8));
      chk("R6 block flag", fill_block, 1);
      chk("R6 cmpl on last", cmpl, (b == 3));
      tick;
    end
    #2;
    chk("R9 after block", fill_addr, 32'h0000_2222);
    chk("R9 cmpl", cmpl, 1);
    tick;
    resp_valid = 0;
    tick;
    #2 chk("R4 idle beat none", cmpl, 0);

    // swap warning with only one pending
    issue(32'h0000_0C0C, 1'b0, 1'b0, 3'd2);
    swap_in = 1;
    tick;
    swap_in = 0;
    chk("R8 swap_err", swap_err, 1);
    resp_valid = 1;
    #2;
    chk("R4 fallback addr", fill_addr, 32'h0000_0C0C);
    chk("R4 fallback cmpl", cmpl, 1);
    tick;
    resp_valid = 0;
    chk("R8 err clears", swap_err, 0);

    // fetch type changed outside accept cycle is ignored
    issue(32'h0000_0D00, 1'b0, 1'b0, 3'd4);
    req_instr = 1; req_len = 3'd1;
    tick;
    tick;
    resp_valid = 1;
    #2;
    chk("R5 instr ignored", fill_instr, 0);
    chk("R5 len ignored", fill_len, 4);
    tick;
    resp_valid = 0; req_instr = 0; req_len = 0;
    tick;

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule